// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block sits between a Wishbone bus master and the rest of a serial port: the receiver, the transmitter and the two word queues that buffer their data. It decodes an 8-bit byte address. One address works as a data window: a read takes the oldest received word and a write queues a word for sending. The other addresses show the fill level of each queue, or hold the line framing, the sample points, the 16-bit bit period and the soft-reset controls. Each of these has a fixed value after reset.

The block drives the framing and timing settings to the serial engines. It also drives registered status flags, which can serve as interrupt sources, and one reset line for each subunit. A subunit reset comes either from a self-clearing soft-reset write or from a bus reset. A per-subunit mask decides which subunits a bus reset also clears. The mask is cleared only by the power-on reset, so its setting survives a bus reset. The queue storage and the serial engines are outside this block. The block reaches the queues through a show-ahead pop port, a push port and a level input for each.

Top module: `uart_csr_bank`

## Requirements
- R1: `wb_ack_o` rises in the cycle after `wb_cyc_i` and `wb_stb_i` are sampled high, and stays high for exactly one cycle. With either strobe low, no acknowledge is given. After `por` or `wb_rst`, `wb_ack_o`, `wb_dat_o`, `rxq_pop` and `txq_push` are 0.
- R2: A read of address 0x00 returns `rxq_rdata` and raises `rxq_pop` for one cycle, together with the acknowledge. When `rxq_level` is 0, the read returns 0x00 and `rxq_pop` stays low.
- R3: A write to address 0x00 raises `txq_push` for one cycle, together with the acknowledge, and `txq_wdata` carries the written byte. When `txq_level` equals the queue depth (64), the push is dropped and `txq_push` stays low.
- R4: A read of address 0x02 returns `rxq_level`, zero-extended. A read of address 0x03 returns `txq_level`, zero-extended.
- R5: After `por`, the registers read as follows: 0x01 reads 0x00, 0x04 reads 0x88, 0x05 reads 0x64, 0x06 reads 0x61 and 0x07 reads 0x51. The bit period is 20833. Address 0x09 reads 0x00.
- R6: Address 0x01 bit 0 is the receive enable and its other bits read 0. In address 0x04, bit 7 is the idle level, bit 6 the parity enable, bit 5 the parity type (1 = odd), bits 4:3 the stop-bit count and bits 2:0 the word-width code. In address 0x05, bits 7:4 are the start sample point and bits 3:0 the mid sample point. Address 0x06 is bit period bits 7:0 and address 0x07 is bits 15:8. Each field reads back what was written and drives its output.
- R7: A write to address 0x02, 0x03 or any address above 0x09 changes no register. A read of any address above 0x09 returns 0x00.
- R8: Address 0x08 reads 0x00. Bit positions in a write to it: bit 4 = receiver, bit 3 = receive queue, bit 2 = transmitter, bit 1 = transmit queue, bit 0 = setup. A 1 in bits 4:1 gives a one-cycle pulse on `rst_rx`, `rst_rxq`, `rst_tx` or `rst_txq`, in the cycle after the acknowledge edge. A 1 in bit 0 returns addresses 0x01 and 0x04 to 0x07 to their R5 values.
- R9: Address 0x09 holds a 5-bit mask with the same bit positions as address 0x08, and bits 7:5 read 0. A `wb_rst` sampled high asserts, one cycle later, every subunit reset whose mask bit is 1. Mask bit 0 also reinitialises the setup registers. The mask itself is kept through `wb_rst`. `por` clears the mask and asserts every subunit reset.
- R10: `rx_empty`, `rx_full`, `tx_empty`, `tx_full` and `tx_sending` follow `rxq_level == 0`, `rxq_level == 64`, `txq_level == 0`, `txq_level == 64` and `tx_busy`, with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, clears everything including the mask |
| wb_rst | input | 1 | Synchronous bus reset, clears the bus side and the masked subunits |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 8 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, registered |
| wb_ack_o | output | 1 | Acknowledge |
| rxq_pop | output | 1 | Pop request to the receive queue |
| rxq_rdata | input | 8 | Head word of the receive queue (show-ahead) |
| rxq_level | input | 7 | Receive queue fill level |
| txq_push | output | 1 | Push request to the transmit queue |
| txq_wdata | output | 8 | Word to push |
| txq_level | input | 7 | Transmit queue fill level |
| tx_busy | input | 1 | Transmitter is shifting a frame |
| rx_en | output | 1 | Receive enable |
| idle_hi | output | 1 | Idle line level |
| par_en | output | 1 | Parity enable |
| par_odd | output | 1 | Parity type, 1 = odd |
| stop_cnt | output | 2 | Stop-bit count code |
| word_w | output | 3 | Word-width code |
| start_pt | output | 4 | Start-bit sample point |
| mid_pt | output | 4 | Data sample point |
| bit_period | output | 16 | Bit period in clock cycles |
| rst_rx | output | 1 | Receiver reset |
| rst_rxq | output | 1 | Receive queue reset |
| rst_tx | output | 1 | Transmitter reset |
| rst_txq | output | 1 | Transmit queue reset |
| rx_empty | output | 1 | Receive queue empty flag |
| rx_full | output | 1 | Receive queue full flag |
| tx_empty | output | 1 | Transmit queue empty flag |
| tx_full | output | 1 | Transmit queue full flag |
| tx_sending | output | 1 | Transmitter busy flag |

## Verification
Several outputs update on the edge that samples the strobe: the acknowledge, the read data, the pop and push pulses and the soft-reset pulses. The bench drives at the falling edge and reads all of these at the falling edge just after that rising edge. It then checks one cycle later that the pulses have gone low. A setup reset takes one cycle more, so its register values are read back only in a later access. The status flags and the bus-reset lines are sampled one falling edge after the input change that the rising edge registered. The level and address sweeps compute every expected byte from the requirement's bit layout.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int unsigned ADR_W = 8;
  localparam int unsigned DAT_W = 8;
  localparam int unsigned PER_W = 16;
  localparam int unsigned N_SUB = 5;

  localparam logic [ADR_W-1:0] A_DATA  = 8'h00;
  localparam logic [ADR_W-1:0] A_RXEN  = 8'h01;
  localparam logic [ADR_W-1:0] A_RXLVL = 8'h02;
  localparam logic [ADR_W-1:0] A_TXLVL = 8'h03;
  localparam logic [ADR_W-1:0] A_FRAME = 8'h04;
  localparam logic [ADR_W-1:0] A_SMPL  = 8'h05;
  localparam logic [ADR_W-1:0] A_PERL  = 8'h06;
  localparam logic [ADR_W-1:0] A_PERH  = 8'h07;
  localparam logic [ADR_W-1:0] A_SRST  = 8'h08;
  localparam logic [ADR_W-1:0] A_RMASK = 8'h09;

  // subunit index = bit position in the soft-reset and mask registers
  localparam int unsigned SUB_SETUP = 0;
  localparam int unsigned SUB_TXQ   = 1;
  localparam int unsigned SUB_TX    = 2;
  localparam int unsigned SUB_RXQ   = 3;
  localparam int unsigned SUB_RX    = 4;

  typedef struct packed {
    logic       idle_hi;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop_cnt;
    logic [2:0] word_w;
  } frame_t;

  typedef struct packed {
    logic [3:0] start_pt;
    logic [3:0] mid_pt;
  } smpl_t;

  localparam frame_t FRAME_RST = 8'h88;
  localparam smpl_t  SMPL_RST  = 8'h64;
endpackage

// File: rtl/uart_csr_bus.sv
module uart_csr_bus (
  input  logic clk,
  input  logic bus_rst,
  input  logic cyc,
  input  logic stb,
  input  logic we,
  output logic ack,
  output logic acc_wr,
  output logic acc_rd
);
  logic take;

  assign take   = cyc & stb & ~ack & ~bus_rst;
  assign acc_wr = take & we;
  assign acc_rd = take & ~we;

  always_ff @(posedge clk) begin
    if (bus_rst) ack <= 1'b0;
    else         ack <= take;
  end

  // R1
  ack_single_chk: assert property (@(posedge clk) disable iff (bus_rst)
    ack |=> !ack);
  // R1
  ack_due_chk: assert property (@(posedge clk) disable iff (bus_rst)
    (cyc && stb && !ack) |=> ack);
  // R1
  ack_no_req_chk: assert property (@(posedge clk) disable iff (bus_rst)
    !(cyc && stb) |=> !ack);
endmodule

// File: rtl/uart_csr_cfg.sv
module uart_csr_cfg
  import uart_csr_pkg::*;
#(
  parameter logic [PER_W-1:0] RST_PERIOD = 16'd20833
) (
  input  logic             clk,
  input  logic             por,
  input  logic             setup_rst,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] adr,
  input  logic [DAT_W-1:0] dat,
  output logic             rx_en,
  output frame_t           frame,
  output smpl_t            smpl,
  output logic [PER_W-1:0] period,
  output logic [N_SUB-1:0] mask,
  output logic [DAT_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (por || setup_rst) begin
      rx_en  <= 1'b0;
      frame  <= FRAME_RST;
      smpl   <= SMPL_RST;
      period <= RST_PERIOD;
    end else if (wr_en) begin
      case (adr)
        A_RXEN:  rx_en        <= dat[0];
        A_FRAME: frame        <= frame_t'(dat);
        A_SMPL:  smpl         <= smpl_t'(dat);
        A_PERL:  period[7:0]  <= dat;
        A_PERH:  period[15:8] <= dat;
        default: ;
      endcase
    end
  end

  // only the power-on reset clears the mask, so it outlives a bus reset
  always_ff @(posedge clk) begin
    if (por)                          mask <= '0;
    else if (wr_en && adr == A_RMASK) mask <= dat[N_SUB-1:0];
  end

  always_comb begin
    case (adr)
      A_RXEN:  rd_data = DAT_W'(rx_en);
      A_FRAME: rd_data = frame;
      A_SMPL:  rd_data = smpl;
      A_PERL:  rd_data = period[7:0];
      A_PERH:  rd_data = period[15:8];
      A_RMASK: rd_data = DAT_W'(mask);
      default: rd_data = '0;
    endcase
  end

  // R8
  setup_reinit_chk: assert property (@(posedge clk) disable iff (por)
    setup_rst |=> (frame == FRAME_RST && smpl == SMPL_RST && period == RST_PERIOD && !rx_en));
  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (por)
    !(wr_en && adr == A_RMASK) |=> $stable(mask));
endmodule

// File: rtl/uart_csr_rst.sv
module uart_csr_rst
  import uart_csr_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             wb_rst,
  input  logic             soft_wr,
  input  logic [N_SUB-1:0] soft_bits,
  input  logic [N_SUB-1:0] mask,
  output logic [N_SUB-1:0] sub_rst
);
  for (genvar i = 0; i < N_SUB; i++) begin : g_sub
    logic soft_q;
    logic bus_q;

    always_ff @(posedge clk) begin
      if (por) begin
        soft_q <= 1'b0;
        bus_q  <= 1'b1;
      end else begin
        soft_q <= soft_wr & soft_bits[i];
        bus_q  <= wb_rst & mask[i];
      end
    end

    assign sub_rst[i] = soft_q | bus_q;

    // R8
    soft_pulse_chk: assert property (@(posedge clk) disable iff (por)
      soft_q |=> !soft_q);
    // R9
    masked_reset_chk: assert property (@(posedge clk) disable iff (por)
      (wb_rst && mask[i]) |=> sub_rst[i]);
  end
endmodule

// File: rtl/uart_csr_queue.sv
module uart_csr_queue
  import uart_csr_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             bus_rst,
  input  logic             rd_req,
  input  logic             wr_req,
  input  logic [DAT_W-1:0] wdat,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic             tx_busy,
  output logic             rxq_pop,
  output logic             txq_push,
  output logic [DAT_W-1:0] txq_wdata,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             tx_sending
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (bus_rst) begin
      rxq_pop   <= 1'b0;
      txq_push  <= 1'b0;
      txq_wdata <= '0;
    end else begin
      rxq_pop  <= rd_req && rx_lvl != '0;
      txq_push <= wr_req && tx_lvl < LVL_FULL;
      if (wr_req) txq_wdata <= wdat;
    end
  end

  always_ff @(posedge clk) begin
    rx_empty   <= rx_lvl == '0;
    rx_full    <= rx_lvl == LVL_FULL;
    tx_empty   <= tx_lvl == '0;
    tx_full    <= tx_lvl == LVL_FULL;
    tx_sending <= tx_busy;
  end

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (bus_rst)
    rxq_pop |-> $past(rx_lvl) != '0);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (bus_rst)
    txq_push |-> $past(tx_lvl) < LVL_FULL);
  // R2
  pop_single_chk: assert property (@(posedge clk) disable iff (bus_rst)
    rxq_pop |=> !rxq_pop);
  // R10
  rx_flag_chk: assert property (@(posedge clk) disable iff (bus_rst)
    (rx_lvl == '0) |=> (rx_empty && !rx_full));
  // R10
  busy_flag_chk: assert property (@(posedge clk) disable iff (bus_rst)
    tx_busy |=> tx_sending);
endmodule

// File: rtl/uart_csr_bank.sv
module uart_csr_bank
  import uart_csr_pkg::*;
#(
  parameter int unsigned      DEPTH      = 64,
  parameter logic [15:0]      RST_PERIOD = 16'd20833,
  localparam int unsigned     LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             por,
  input  logic             wb_rst,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [7:0]       wb_adr_i,
  input  logic [7:0]       wb_dat_i,
  output logic [7:0]       wb_dat_o,
  output logic             wb_ack_o,
  output logic             rxq_pop,
  input  logic [7:0]       rxq_rdata,
  input  logic [LVL_W-1:0] rxq_level,
  output logic             txq_push,
  output logic [7:0]       txq_wdata,
  input  logic [LVL_W-1:0] txq_level,
  input  logic             tx_busy,
  output logic             rx_en,
  output logic             idle_hi,
  output logic             par_en,
  output logic             par_odd,
  output logic [1:0]       stop_cnt,
  output logic [2:0]       word_w,
  output logic [3:0]       start_pt,
  output logic [3:0]       mid_pt,
  output logic [15:0]      bit_period,
  output logic             rst_rx,
  output logic             rst_rxq,
  output logic             rst_tx,
  output logic             rst_txq,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             tx_sending
);
  logic             bus_rst;
  logic             acc_wr, acc_rd;
  frame_t           frame;
  smpl_t            smpl;
  logic [N_SUB-1:0] mask;
  logic [N_SUB-1:0] sub_rst;
  logic [DAT_W-1:0] cfg_rd;
  logic [DAT_W-1:0] rd_mux;
  logic             data_sel;

  assign bus_rst  = por | wb_rst;
  assign data_sel = wb_adr_i == A_DATA;

  uart_csr_bus u_bus (
    .clk     (clk),
    .bus_rst (bus_rst),
    .cyc     (wb_cyc_i),
    .stb     (wb_stb_i),
    .we      (wb_we_i),
    .ack     (wb_ack_o),
    .acc_wr  (acc_wr),
    .acc_rd  (acc_rd)
  );

  uart_csr_cfg #(.RST_PERIOD(RST_PERIOD)) u_cfg (
    .clk       (clk),
    .por       (por),
    .setup_rst (sub_rst[SUB_SETUP]),
    .wr_en     (acc_wr),
    .adr       (wb_adr_i),
    .dat       (wb_dat_i),
    .rx_en     (rx_en),
    .frame     (frame),
    .smpl      (smpl),
    .period    (bit_period),
    .mask      (mask),
    .rd_data   (cfg_rd)
  );

  uart_csr_rst u_rst (
    .clk       (clk),
    .por       (por),
    .wb_rst    (wb_rst),
    .soft_wr   (acc_wr && wb_adr_i == A_SRST),
    .soft_bits (wb_dat_i[N_SUB-1:0]),
    .mask      (mask),
    .sub_rst   (sub_rst)
  );

  uart_csr_queue #(.DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .bus_rst    (bus_rst),
    .rd_req     (acc_rd && data_sel),
    .wr_req     (acc_wr && data_sel),
    .wdat       (wb_dat_i),
    .rx_lvl     (rxq_level),
    .tx_lvl     (txq_level),
    .tx_busy    (tx_busy),
    .rxq_pop    (rxq_pop),
    .txq_push   (txq_push),
    .txq_wdata  (txq_wdata),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .tx_empty   (tx_empty),
    .tx_full    (tx_full),
    .tx_sending (tx_sending)
  );

  always_comb begin
    case (wb_adr_i)
      A_DATA:  rd_mux = (rxq_level != '0) ? rxq_rdata : '0;
      A_RXLVL: rd_mux = DAT_W'(rxq_level);
      A_TXLVL: rd_mux = DAT_W'(txq_level);
      default: rd_mux = cfg_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (bus_rst)     wb_dat_o <= '0;
    else if (acc_rd) wb_dat_o <= rd_mux;
  end

  assign idle_hi  = frame.idle_hi;
  assign par_en   = frame.par_en;
  assign par_odd  = frame.par_odd;
  assign stop_cnt = frame.stop_cnt;
  assign word_w   = frame.word_w;
  assign start_pt = smpl.start_pt;
  assign mid_pt   = smpl.mid_pt;
  assign rst_rx   = sub_rst[SUB_RX];
  assign rst_rxq  = sub_rst[SUB_RXQ];
  assign rst_tx   = sub_rst[SUB_TX];
  assign rst_txq  = sub_rst[SUB_TXQ];

  // R2
  empty_read_chk: assert property (@(posedge clk) disable iff (bus_rst)
    (acc_rd && data_sel && rxq_level == '0) |=> (wb_dat_o == '0 && !rxq_pop));
  // R7
  unused_read_chk: assert property (@(posedge clk) disable iff (bus_rst)
    (acc_rd && wb_adr_i > A_RMASK) |=> wb_dat_o == '0);
  // R8
  srst_read_chk: assert property (@(posedge clk) disable iff (bus_rst)
    (acc_rd && wb_adr_i == A_SRST) |=> wb_dat_o == '0);
endmodule

// File: tb/uart_csr_bank_tb_top.sv
module uart_csr_bank_tb_top;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       por = 1'b1, wb_rst = 1'b0;
  logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [7:0] adr = '0, wdat = '0;
  logic [7:0] dat_o;
  logic       ack;
  logic       rxq_pop, txq_push;
  logic [7:0] rxq_rdata = '0, txq_wdata;
  logic [6:0] rxq_level = '0, txq_level = '0;
  logic       tx_busy = 1'b0;
  logic       rx_en, idle_hi, par_en, par_odd;
  logic [1:0] stop_cnt;
  logic [2:0] word_w;
  logic [3:0] start_pt, mid_pt;
  logic [15:0] bit_period;
  logic       rst_rx, rst_rxq, rst_tx, rst_txq;
  logic       rx_empty, rx_full, tx_empty, tx_full, tx_sending;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rd_val;
  logic       s_ack, s_pop, s_push;
  logic [7:0] s_wdata;
  logic [3:0] s_rst;

  always #5 clk = ~clk;

  uart_csr_bank dut_i (
    .clk(clk), .por(por), .wb_rst(wb_rst),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat),
    .wb_dat_o(dat_o), .wb_ack_o(ack),
    .rxq_pop(rxq_pop), .rxq_rdata(rxq_rdata), .rxq_level(rxq_level),
    .txq_push(txq_push), .txq_wdata(txq_wdata), .txq_level(txq_level), .tx_busy(tx_busy),
    .rx_en(rx_en), .idle_hi(idle_hi), .par_en(par_en), .par_odd(par_odd),
    .stop_cnt(stop_cnt), .word_w(word_w), .start_pt(start_pt), .mid_pt(mid_pt),
    .bit_period(bit_period),
    .rst_rx(rst_rx), .rst_rxq(rst_rxq), .rst_tx(rst_tx), .rst_txq(rst_txq),
    .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full),
    .tx_sending(tx_sending)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one bus access; samples every same-edge result at the next falling edge
  task automatic access(input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(posedge clk);
    @(negedge clk);
    s_ack = ack; rd_val = dat_o; s_pop = rxq_pop; s_push = txq_push; s_wdata = txq_wdata;
    s_rst = {rst_rx, rst_rxq, rst_tx, rst_txq};
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input int exp);
    access(1'b0, a, 8'h00);
    check({tag, " ack"}, s_ack, 1);
    check(tag, rd_val, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    access(1'b1, a, d);
  endtask

  task automatic check_defaults(input string tag);
    rd(8'h01, {tag, " rxen"}, 8'h00);
    rd(8'h04, {tag, " frame"}, 8'h88);
    rd(8'h05, {tag, " sample"}, 8'h64);
    rd(8'h06, {tag, " per lo"}, 20833 % 256);
    rd(8'h07, {tag, " per hi"}, 20833 / 256);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9 power-on reset asserts every subunit reset
    check("R9 por rst lines", {rst_rx, rst_rxq, rst_tx, rst_txq}, 4'hF);
    // R1 reset state of bus side
    check("R1 reset ack", ack, 0);
    check("R1 reset dat", dat_o, 0);
    check("R1 reset pop/push", {rxq_pop, txq_push}, 0);
    por = 1'b0;
    @(negedge clk);
    check("R9 rst lines after por", {rst_rx, rst_rxq, rst_tx, rst_txq}, 0);

    // R5 reset values
    check_defaults("R5");
    rd(8'h09, "R5 mask", 8'h00);
    check("R5 period out", bit_period, 20833);

    // R1 no acknowledge without strobe
    @(negedge clk); cyc = 1'b1; stb = 1'b0;
    @(negedge clk); check("R1 cyc only", ack, 0);
    cyc = 1'b0; stb = 1'b1;
    @(negedge clk); check("R1 stb only", ack, 0);
    stb = 1'b0;
    @(negedge clk); check("R1 ack drops", ack, 0);

    // R7 unused addresses read 0 (sweep)
    for (int a = 10; a < 256; a++) rd(8'(a), "R7 unused read", 0);

    // R2 empty pop
    rxq_level = 0; rxq_rdata = 8'hA5;
    rd(8'h00, "R2 empty read", 0);
    check("R2 empty no pop", s_pop, 0);

    // R2 pops with data patterns
    rxq_level = 7'd5;
    for (int v = 0; v < 256; v += 37) begin
      rxq_rdata = 8'(v);
      rd(8'h00, "R2 pop data", v);
      check("R2 pop pulse", s_pop, 1);
      @(negedge clk);
      check("R2 pop single", rxq_pop, 0);
    end

    // R3 push and full drop
    txq_level = 7'd10;
    for (int v = 3; v < 256; v += 51) begin
      wr(8'h00, 8'(v));
      check("R3 push pulse", s_push, 1);
      check("R3 push data", s_wdata, v);
      @(negedge clk);
      check("R3 push single", txq_push, 0);
    end
    txq_level = 7'd64;
    wr(8'h00, 8'h3C);
    check("R3 full drop", s_push, 0);
    txq_level = 7'd63;
    wr(8'h00, 8'h3D);
    check("R3 one slot left", s_push, 1);

    // R4 / R10 level sweep
    for (int l = 0; l <= DEPTH; l++) begin
      rxq_level = 7'(l); txq_level = 7'(DEPTH - l); tx_busy = l[0];
      rd(8'h02, "R4 rx level", l);
      rd(8'h03, "R4 tx level", DEPTH - l);
      check("R10 rx_empty", rx_empty, l == 0);
      check("R10 rx_full", rx_full, l == DEPTH);
      check("R10 tx_empty", tx_empty, l == DEPTH);
      check("R10 tx_full", tx_full, l == 0);
      check("R10 tx_sending", tx_sending, l % 2);
    end
    // R10 one-cycle delay on the flag
    @(negedge clk); rxq_level = 7'd0;
    @(negedge clk); check("R10 empty delayed", rx_empty, 1);
    rxq_level = 7'd1;
    check("R10 not yet", rx_empty, 1);
    @(negedge clk); check("R10 updated", rx_empty, 0);

    // R6 frame register sweep and field positions
    for (int v = 0; v < 256; v++) begin
      wr(8'h04, 8'(v));
      rd(8'h04, "R6 frame readback", v);
    end
    wr(8'h04, 8'b1_0_1_10_101);
    check("R6 frame fields", {idle_hi, par_en, par_odd, stop_cnt, word_w}, {1'b1, 1'b0, 1'b1, 2'd2, 3'd5});
    wr(8'h05, 8'h9C);
    check("R6 sample fields", {start_pt, mid_pt}, 8'h9C);
    rd(8'h05, "R6 sample read", 8'h9C);
    wr(8'h01, 8'hFF);
    rd(8'h01, "R6 rxen read", 8'h01);
    check("R6 rxen out", rx_en, 1);
    wr(8'h06, 8'h34); wr(8'h07, 8'h12);
    check("R6 period out", bit_period, 16'h1234);

    // R7 writes to read-only and unused addresses ignored
    wr(8'h02, 8'hFF); wr(8'h03, 8'hFF); wr(8'h0A, 8'h00); wr(8'h80, 8'h00); wr(8'hFF, 8'h00);
    rd(8'h04, "R7 frame kept", 8'hB5);
    rd(8'h05, "R7 sample kept", 8'h9C);
    rd(8'h06, "R7 per lo kept", 8'h34);
    rd(8'h07, "R7 per hi kept", 8'h12);
    rd(8'h09, "R7 mask kept", 8'h00);
    rd(8'h0A, "R7 still zero", 0);

    // R8 soft reset pulses, one subunit at a time
    for (int i = 1; i < 5; i++) begin
      wr(8'h08, 8'(1 << i));
      // s_rst = {rx, rxq, tx, txq} = bits 4..1
      check("R8 soft pulse", s_rst, 1 << (i - 1));
      @(negedge clk);
      check("R8 pulse cleared", {rst_rx, rst_rxq, rst_tx, rst_txq}, 0);
    end
    rd(8'h08, "R8 reads zero", 0);
    rd(8'h04, "R8 no setup side effect", 8'hB5);
    wr(8'h08, 8'h01);
    check("R8 setup bit no line", s_rst, 0);
    check_defaults("R8 setup reset");

    // R9 mask and bus reset
    wr(8'h09, 8'hFF);
    rd(8'h09, "R9 mask width", 8'h1F);
    wr(8'h09, 8'h15);
    wr(8'h04, 8'h11); wr(8'h01, 8'h01);
    @(negedge clk); wb_rst = 1'b1;
    @(negedge clk);
    check("R9 masked lines", {rst_rx, rst_rxq, rst_tx, rst_txq}, 4'b1010);
    check("R1 wb_rst ack", ack, 0);
    wb_rst = 1'b0;
    @(negedge clk);
    check_defaults("R9 setup via mask");
    rd(8'h09, "R9 mask kept", 8'h15);
    wr(8'h09, 8'h00);
    wr(8'h04, 8'h22);
    @(negedge clk); wb_rst = 1'b1;
    @(negedge clk);
    check("R9 unmasked lines", {rst_rx, rst_rxq, rst_tx, rst_txq}, 0);
    wb_rst = 1'b0;
    @(negedge clk);
    rd(8'h04, "R9 setup not masked", 8'h22);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule